// File: doc/BRIEF.md
# Two-Level Nested Trap Controller

This unit handles exception entry and return for a balanced-ternary processor whose words are 27 trits wide. Each trit is stored as two bits. A synchronous trap request comes with a source selector, a faulting address, the raw instruction word and the PC of the trapping instruction. The unit turns these into a cause word and a trap-value word. It saves the machine state into one of two save banks and redirects fetch to the trap vector. A return strobe reverses the most recent entry in one cycle.

Nesting is tracked by a three-valued depth field in the status register. At depth Z no handler is running. At depth P one handler is running and its state sits in the main bank. At depth N a second, nested handler is running and its state sits in the second bank. A trap taken at depth N cannot be stored anywhere. The unit therefore performs a machine-check reset: it clears every control register, redirects to address 0 and pulses a strobe that tells the register file to clear itself.

Software reads and writes all control registers through a small address-mapped port. Instruction decode beyond reserved-opcode and system-call classification lies outside this unit, as do the datapath and storage.

Top module: `tnx_trap_ctrl`

## Requirements
- R1: After reset, every control register reads 0, and `redirect_valid`, `mcheck` and `gpr_clear` are low.
- R2: Suppose a trap is requested while the status depth trit is Z. At the next clock edge the main bank captures the old status, `exc_pc`, the cause and the trap value. The status register keeps its other trits, but the depth trit (trit 0) becomes P and the mode trit (trit 1) and the enable trit (trit 2) become N. `redirect_valid` then pulses for one cycle with `redirect_pc` equal to the vector register.
- R3: Suppose a trap is requested while the depth is P. The second bank captures the state instead, the main bank is left unchanged, and the depth becomes N. The redirect still goes to the vector register.
- R4: Suppose a trap is requested while the depth is N. At the next edge every control register is cleared. `mcheck` and `gpr_clear` are high for exactly one cycle, and `redirect_valid` pulses with `redirect_pc` equal to 0.
- R5: Suppose a return is requested while the depth is P. In a single cycle the status register is loaded from the main bank's saved status, and the redirect goes to the main bank's saved PC. At depth N the second bank is used in the same way.
- R6: A return requested while the depth is Z has no effect: there is no redirect and the status register is unchanged.
- R7: The divide-by-zero source (`exc_src` = 0) gives cause −13 with trap value 0, and ignores `exc_addr`. The fault source (`exc_src` = 1) gives cause −11 with the trap value equal to `exc_addr`. Cause and value words are balanced ternary, with trit i weighted 3^i and trit 0 in bits [1:0].
- R8: The instruction source (`exc_src` = 2 or 3) reads the opcode from trits 0 to 3 of `exc_insn`. Opcodes −20, −19 and +14 to +40 are reserved, and they give cause −10 with the trap value equal to the raw instruction word. Any opcode other than the system opcode (default 9) also gives cause −10.
- R9: For the system opcode, trit 10 of the instruction selects the call flavor. Z gives cause 0, P gives cause +1, and N gives cause +2. The trap value is 0 in all three cases.
- R10: Trit codes are 00 for Z, 01 for P and 11 for N. Code 10 is read as Z wherever a trit is decoded, including the status depth and the flavor trit.
- R11: If a trap and a return arrive in the same cycle, the trap is taken and the return is ignored. A CSR write in a cycle that takes a trap or a return is dropped.
- R12: The CSR addresses are as follows:
  - 1 reads `pc_now`, and writes to it are ignored.
  - 2 is logic mode.
  - 3 is flags.
  - 4, 5, 8 and 9 are the main bank's PC, cause, status and value.
  - 6 is the vector.
  - 7 is the status register.
  - 10 to 13 are the second bank's PC, cause, status and value.
  - Addresses 0, 14 and 15 read 0 and ignore writes.
- R13: A CSR write to a saved-PC register is used by a return issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous trap request |
| exc_src | input | 2 | Trap source: 0 divide by zero, 1 fault, 2 or 3 instruction |
| exc_addr | input | 54 | Faulting address for the fault source |
| exc_insn | input | 54 | Raw instruction word for the instruction source |
| exc_pc | input | 54 | PC of the trapping instruction |
| ret_req | input | 1 | Return-from-trap strobe |
| pc_now | input | 54 | Current PC, returned by reads of address 1 |
| csr_addr | input | 4 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | 54 | CSR write data |
| csr_rdata | output | 54 | CSR read data, combinational from `csr_addr` |
| redirect_valid | output | 1 | One-cycle pulse after a trap or an accepted return |
| redirect_pc | output | 54 | Fetch target that goes with `redirect_valid` |
| mcheck | output | 1 | Machine-check reset pulse |
| gpr_clear | output | 1 | Clear-all strobe for the general registers |

## Verification
The inline assertions check the cycle-level rules on every clock. They check that entry at depth Z moves to depth P, and that a nested entry leaves the main bank stable. They check that a return at depth P reloads the status from the saved copy, and that a return at depth Z produces no redirect. They also check that a trap beats a simultaneous return, and that the machine-check pulse lasts one cycle and carries a zero target. Only the bench's scenarios can show the arithmetic side. This covers the cause and value encodings across a sweep of every 4-trit opcode and every flavor code, the full CSR address map, and the triple-fault clear of every register. It also covers the restoring of non-depth status trits on return, and the use of a freshly written saved PC by the next return.

// File: rtl/tnx_trap_pkg.sv
package tnx_trap_pkg;

   typedef logic [1:0] trit_t;

   localparam trit_t T_Z = 2'b00;
   localparam trit_t T_P = 2'b01;
   localparam trit_t T_N = 2'b11;

   // code 10 carries no value; every decoder folds it to zero
   function automatic trit_t tnorm(input trit_t t);
      return (t == 2'b10) ? T_Z : t;
   endfunction

   // status trit positions
   localparam int ST_DEPTH = 0;
   localparam int ST_MODE  = 1;
   localparam int ST_IE    = 2;

   typedef enum logic [1:0] {
      SRC_DIV0     = 2'd0,
      SRC_FAULT    = 2'd1,
      SRC_INSN     = 2'd2,
      SRC_INSN_ALT = 2'd3
   } exc_src_e;

   localparam int CAUSE_DIV0    = -13;
   localparam int CAUSE_FAULT   = -11;
   localparam int CAUSE_ILLEGAL = -10;
   localparam int CAUSE_UCALL   = 0;
   localparam int CAUSE_HCALL   = 1;
   localparam int CAUSE_DBG     = 2;

   localparam int RSV_A      = -20;
   localparam int RSV_B      = -19;
   localparam int RSV_HI_MIN = 14;
   localparam int RSV_HI_MAX = 40;

   // control register addresses
   localparam int CSR_PC     = 1;
   localparam int CSR_LOGIC  = 2;
   localparam int CSR_FLAGS  = 3;
   localparam int CSR_VECTOR = 6;
   localparam int CSR_STATUS = 7;

   // save bank field indices
   localparam int FLD_PC    = 0;
   localparam int FLD_CAUSE = 1;
   localparam int FLD_STAT  = 2;
   localparam int FLD_VAL   = 3;
   localparam int NUM_FLD   = 4;
   localparam int NUM_BANK  = 2;

   // address of field f in bank b
   function automatic int bank_addr(input int b, input int f);
      int a;
      case (f)
         FLD_PC:    a = 4;
         FLD_CAUSE: a = 5;
         FLD_STAT:  a = 8;
         default:   a = 9;
      endcase
      return (b == 0) ? a : ((f == FLD_PC) ? 10 : (f == FLD_CAUSE) ? 11 :
                             (f == FLD_STAT) ? 12 : 13);
   endfunction

endpackage

// File: rtl/tnx_trap_classify.sv
module tnx_trap_classify
   import tnx_trap_pkg::*;
#(
   parameter int unsigned WORD_TRITS = 27,
   parameter int unsigned OPC_TRITS  = 4,
   parameter int unsigned IMM_POS    = 10,
   parameter int          SYS_OPC    = 9
) (
   input  logic [1:0]              src,
   input  logic [2*WORD_TRITS-1:0] addr,
   input  logic [2*WORD_TRITS-1:0] insn,
   output logic [2*WORD_TRITS-1:0] cause,
   output logic [2*WORD_TRITS-1:0] tval
);

   localparam int unsigned WB = 2 * WORD_TRITS;

   // elaboration-time parameter checks
   if (OPC_TRITS < 4 || OPC_TRITS > 19) begin : g_bad_opc
      $error("OPC_TRITS must lie in 4..19");
   end
   if (IMM_POS < OPC_TRITS || IMM_POS >= WORD_TRITS) begin : g_bad_imm
      $error("IMM_POS must sit above the opcode and inside the word");
   end
   if (SYS_OPC == RSV_A || SYS_OPC == RSV_B ||
       (SYS_OPC >= RSV_HI_MIN && SYS_OPC <= RSV_HI_MAX)) begin : g_bad_sys
      $error("SYS_OPC must not be a reserved opcode");
   end

   function automatic logic [WB-1:0] enc(input int v);
      int x;
      int m;
      logic [WB-1:0] r;
      x = v;
      r = '0;
      for (int i = 0; i < int'(WORD_TRITS); i++) begin
         m = x % 3;
         if (m < 0) m += 3;
         if (m == 1) begin
            r[2*i +: 2] = T_P;
            x = (x - 1) / 3;
         end else if (m == 2) begin
            r[2*i +: 2] = T_N;
            x = (x + 1) / 3;
         end else begin
            x = x / 3;
         end
      end
      return r;
   endfunction

   localparam logic [WB-1:0] W_DIV0    = enc(CAUSE_DIV0);
   localparam logic [WB-1:0] W_FAULT   = enc(CAUSE_FAULT);
   localparam logic [WB-1:0] W_ILLEGAL = enc(CAUSE_ILLEGAL);
   localparam logic [WB-1:0] W_UCALL   = enc(CAUSE_UCALL);
   localparam logic [WB-1:0] W_HCALL   = enc(CAUSE_HCALL);
   localparam logic [WB-1:0] W_DBG     = enc(CAUSE_DBG);

   // per-trit digit of the opcode field
   int digit [OPC_TRITS];
   for (genvar g = 0; g < int'(OPC_TRITS); g++) begin : g_dig
      trit_t tn;
      assign tn = tnorm(insn[2*g +: 2]);
      assign digit[g] = (tn == T_P) ? 1 : (tn == T_N) ? -1 : 0;
   end

   int    opc_val;
   logic  is_rsv;
   logic  is_sys;
   trit_t flav;

   always_comb begin
      opc_val = 0;
      for (int i = int'(OPC_TRITS) - 1; i >= 0; i--) begin
         opc_val = opc_val * 3 + digit[i];
      end
   end

   assign is_rsv = (opc_val == RSV_A) || (opc_val == RSV_B) ||
                   (opc_val >= RSV_HI_MIN && opc_val <= RSV_HI_MAX);
   assign is_sys = !is_rsv && (opc_val == SYS_OPC);
   assign flav   = tnorm(insn[2*IMM_POS +: 2]);

   always_comb begin
      cause = W_ILLEGAL;
      tval  = insn;
      case (exc_src_e'(src))
         SRC_DIV0: begin
            cause = W_DIV0;
            tval  = '0;
         end
         SRC_FAULT: begin
            cause = W_FAULT;
            tval  = addr;
         end
         default: begin
            if (is_sys) begin
               tval = '0;
               case (flav)
                  T_P:     cause = W_HCALL;
                  T_N:     cause = W_DBG;
                  default: cause = W_UCALL;
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/tnx_save_bank.sv
module tnx_save_bank
   import tnx_trap_pkg::*;
#(
   parameter int unsigned WORD_TRITS = 27,
   parameter int unsigned NFLD       = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             save_en,
   input  logic [NFLD-1:0][2*WORD_TRITS-1:0] save_d,
   input  logic [NFLD-1:0]                  wr_en,
   input  logic [2*WORD_TRITS-1:0]          wr_d,
   output logic [NFLD-1:0][2*WORD_TRITS-1:0] fld_q
);

   localparam int unsigned WB = 2 * WORD_TRITS;

   if (NFLD < 1) begin : g_bad_nfld
      $error("NFLD must be at least 1");
   end

   for (genvar f = 0; f < int'(NFLD); f++) begin : g_fld
      logic [WB-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (clr) begin
            q <= '0;
         end else if (save_en) begin
            q <= save_d[f];
         end else if (wr_en[f]) begin
            q <= wr_d;
         end
      end
      assign fld_q[f] = q;
   end

endmodule

// File: rtl/tnx_trap_ctrl.sv
module tnx_trap_ctrl
   import tnx_trap_pkg::*;
#(
   parameter int unsigned WORD_TRITS = 27,
   parameter int unsigned OPC_TRITS  = 4,
   parameter int unsigned IMM_POS    = 10,
   parameter int          SYS_OPC    = 9,
   parameter int unsigned CSR_AW     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    exc_req,
   input  logic [1:0]              exc_src,
   input  logic [2*WORD_TRITS-1:0] exc_addr,
   input  logic [2*WORD_TRITS-1:0] exc_insn,
   input  logic [2*WORD_TRITS-1:0] exc_pc,
   input  logic                    ret_req,
   input  logic [2*WORD_TRITS-1:0] pc_now,
   input  logic [CSR_AW-1:0]       csr_addr,
   input  logic                    csr_we,
   input  logic [2*WORD_TRITS-1:0] csr_wdata,
   output logic [2*WORD_TRITS-1:0] csr_rdata,
   output logic                    redirect_valid,
   output logic [2*WORD_TRITS-1:0] redirect_pc,
   output logic                    mcheck,
   output logic                    gpr_clear
);

   localparam int unsigned WB = 2 * WORD_TRITS;

   if (CSR_AW < 4) begin : g_bad_aw
      $error("CSR_AW must be at least 4 to reach address 13");
   end
   if (WORD_TRITS <= ST_IE) begin : g_bad_word
      $error("WORD_TRITS too small to hold the status fields");
   end

   localparam logic [CSR_AW-1:0] A_PC     = CSR_AW'(CSR_PC);
   localparam logic [CSR_AW-1:0] A_LOGIC  = CSR_AW'(CSR_LOGIC);
   localparam logic [CSR_AW-1:0] A_FLAGS  = CSR_AW'(CSR_FLAGS);
   localparam logic [CSR_AW-1:0] A_VECTOR = CSR_AW'(CSR_VECTOR);
   localparam logic [CSR_AW-1:0] A_STATUS = CSR_AW'(CSR_STATUS);

   // ---------------- cause classification ----------------
   logic [WB-1:0] cls_cause;
   logic [WB-1:0] cls_tval;

   tnx_trap_classify #(
      .WORD_TRITS (WORD_TRITS),
      .OPC_TRITS  (OPC_TRITS),
      .IMM_POS    (IMM_POS),
      .SYS_OPC    (SYS_OPC)
   ) u_classify (
      .src   (exc_src),
      .addr  (exc_addr),
      .insn  (exc_insn),
      .cause (cls_cause),
      .tval  (cls_tval)
   );

   // ---------------- status and plain registers ----------------
   logic [WB-1:0] status_q;
   logic [WB-1:0] logic_q;
   logic [WB-1:0] flags_q;
   logic [WB-1:0] vector_q;

   trit_t dep;
   logic  triple;
   logic  ret_go;
   logic  ret_bank;
   logic  wr_ok;
   logic [WB-1:0] entered;

   assign dep      = tnorm(status_q[2*ST_DEPTH +: 2]);
   assign triple   = exc_req && (dep == T_N);
   assign ret_go   = ret_req && !exc_req && (dep != T_Z);
   assign ret_bank = (dep == T_N);
   assign wr_ok    = csr_we && !exc_req && !ret_go;

   always_comb begin
      entered = status_q;
      entered[2*ST_MODE  +: 2] = T_N;
      entered[2*ST_IE    +: 2] = T_N;
      entered[2*ST_DEPTH +: 2] = (dep == T_Z) ? T_P : T_N;
   end

   // ---------------- save banks ----------------
   logic [NUM_BANK-1:0][NUM_FLD-1:0][WB-1:0] bank_q;
   logic [NUM_FLD-1:0][WB-1:0]               save_d;

   always_comb begin
      save_d            = '0;
      save_d[FLD_PC]    = exc_pc;
      save_d[FLD_CAUSE] = cls_cause;
      save_d[FLD_STAT]  = status_q;
      save_d[FLD_VAL]   = cls_tval;
   end

   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      logic [NUM_FLD-1:0] wr_en;
      logic               save_en;

      for (genvar f = 0; f < NUM_FLD; f++) begin : g_wen
         assign wr_en[f] = wr_ok && (csr_addr == CSR_AW'(bank_addr(b, f)));
      end

      assign save_en = exc_req && (dep == ((b == 0) ? T_Z : T_P));

      tnx_save_bank #(
         .WORD_TRITS (WORD_TRITS),
         .NFLD       (NUM_FLD)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (triple),
         .save_en (save_en),
         .save_d  (save_d),
         .wr_en   (wr_en),
         .wr_d    (csr_wdata),
         .fld_q   (bank_q[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (triple) begin
         status_q <= '0;
      end else if (exc_req) begin
         status_q <= entered;
      end else if (ret_go) begin
         status_q <= bank_q[ret_bank][FLD_STAT];
      end else if (wr_ok && csr_addr == A_STATUS) begin
         status_q <= csr_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         logic_q  <= '0;
         flags_q  <= '0;
         vector_q <= '0;
      end else if (triple) begin
         logic_q  <= '0;
         flags_q  <= '0;
         vector_q <= '0;
      end else if (wr_ok) begin
         if (csr_addr == A_LOGIC)  logic_q  <= csr_wdata;
         if (csr_addr == A_FLAGS)  flags_q  <= csr_wdata;
         if (csr_addr == A_VECTOR) vector_q <= csr_wdata;
      end
   end

   // ---------------- redirect and machine check ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         mcheck         <= 1'b0;
         gpr_clear      <= 1'b0;
      end else begin
         redirect_valid <= exc_req || ret_go;
         mcheck         <= triple;
         gpr_clear      <= triple;
         if (triple) begin
            redirect_pc <= '0;
         end else if (exc_req) begin
            redirect_pc <= vector_q;
         end else if (ret_go) begin
            redirect_pc <= bank_q[ret_bank][FLD_PC];
         end
      end
   end

   // ---------------- CSR read ----------------
   always_comb begin
      csr_rdata = '0;
      if (csr_addr == A_PC)     csr_rdata = pc_now;
      if (csr_addr == A_LOGIC)  csr_rdata = logic_q;
      if (csr_addr == A_FLAGS)  csr_rdata = flags_q;
      if (csr_addr == A_VECTOR) csr_rdata = vector_q;
      if (csr_addr == A_STATUS) csr_rdata = status_q;
      for (int b = 0; b < NUM_BANK; b++) begin
         for (int f = 0; f < NUM_FLD; f++) begin
            if (csr_addr == CSR_AW'(bank_addr(b, f))) csr_rdata = bank_q[b][f];
         end
      end
   end

   // ---------------- assertions ----------------
   a_r2_entry_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && dep == T_Z) |=> (dep == T_P));

   a_r3_main_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && dep == T_P) |=> ($stable(bank_q[0]) && dep == T_N));

   a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mcheck |=> !mcheck);

   a_r4_redirect_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mcheck |-> (redirect_valid && redirect_pc == '0 && gpr_clear));

   a_r5_ret_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !exc_req && dep == T_P) |=>
         (status_q == $past(bank_q[0][FLD_STAT]) && redirect_valid));

   a_r6_ret_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !exc_req && dep == T_Z) |=> (!redirect_valid && $stable(status_q)));

   a_r11_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && ret_req && dep == T_P) |=> (dep == T_N));

endmodule

// File: tb/sim_tnx_trap_ctrl.sv
module sim_tnx_trap_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 27;
   localparam int WB = 2 * W;
   localparam int SYS = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exc_req = 1'b0;
   logic [1:0]    exc_src = 2'd0;
   logic [WB-1:0] exc_addr = '0;
   logic [WB-1:0] exc_insn = '0;
   logic [WB-1:0] exc_pc = '0;
   logic          ret_req = 1'b0;
   logic [WB-1:0] pc_now = '0;
   logic [3:0]    csr_addr = '0;
   logic          csr_we = 1'b0;
   logic [WB-1:0] csr_wdata = '0;
   logic [WB-1:0] csr_rdata;
   logic          redirect_valid;
   logic [WB-1:0] redirect_pc;
   logic          mcheck;
   logic          gpr_clear;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tnx_trap_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_src(exc_src),
      .exc_addr(exc_addr), .exc_insn(exc_insn), .exc_pc(exc_pc),
      .ret_req(ret_req), .pc_now(pc_now), .csr_addr(csr_addr),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .mcheck(mcheck), .gpr_clear(gpr_clear)
   );

   function automatic logic [WB-1:0] tw(input int v);
      int x;
      int m;
      logic [WB-1:0] r;
      x = v;
      r = '0;
      for (int i = 0; i < W; i++) begin
         m = ((x % 3) + 3) % 3;
         if (m == 1) begin r[2*i +: 2] = 2'b01; x = (x - 1) / 3; end
         else if (m == 2) begin r[2*i +: 2] = 2'b11; x = (x + 1) / 3; end
         else x = x / 3;
      end
      return r;
   endfunction

   function automatic logic [WB-1:0] entry(input logic [WB-1:0] old, input logic [1:0] d);
      return {old[WB-1:6], 2'b11, 2'b11, d};
   endfunction

   function automatic logic [WB-1:0] mk_insn(input int op, input logic [1:0] f);
      logic [WB-1:0] w;
      logic [WB-1:0] o;
      logic [WB-1:0] hi;
      o  = tw(op);
      hi = tw(4321);
      w  = '0;
      w[7:0]   = o[7:0];
      w[21:20] = f;
      w[WB-1:24] = hi[WB-25:0];
      return w;
   endfunction

   task automatic chk(input string tag, input logic [WB-1:0] act, input logic [WB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [WB-1:0] v);
      csr_addr = 4'(a);
      #1;
      v = csr_rdata;
   endtask

   task automatic wr(input int a, input logic [WB-1:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = 4'(a); csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic trap(input logic [1:0] s, input logic [WB-1:0] a,
                       input logic [WB-1:0] i, input logic [WB-1:0] p);
      @(negedge clk);
      exc_req = 1'b1; exc_src = s; exc_addr = a; exc_insn = i; exc_pc = p;
      @(negedge clk);
      exc_req = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk);
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [WB-1:0] v;
      logic [WB-1:0] st0;
      pc_now = tw(777);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R12 unmapped addresses
      chk("R1 redirect_valid", {53'd0, redirect_valid}, '0);
      chk("R1 mcheck", {52'd0, mcheck, gpr_clear}, '0);
      for (int a = 0; a < 16; a++) begin
         rd(a, v);
         chk((a == 1) ? "R12 pc read" : "R1 reset csr", v, (a == 1) ? tw(777) : '0);
      end

      // R12 address map write/readback
      for (int a = 2; a <= 13; a++) wr(a, tw(1000 * a + 17));
      wr(1, tw(5));
      wr(14, tw(6));
      for (int a = 1; a <= 14; a++) begin
         rd(a, v);
         chk("R12 map", v, (a == 1) ? tw(777) : (a == 14) ? '0 : tw(1000 * a + 17));
      end

      // R2 R7 R5 single-level entry and return
      st0 = tw(135);
      wr(7, st0);
      wr(6, tw(500));
      trap(2'd0, tw(77), '0, tw(40));
      chk("R2 redirect_valid", {53'd0, redirect_valid}, 54'd1);
      chk("R2 redirect_pc", redirect_pc, tw(500));
      rd(4, v);  chk("R2 saved pc", v, tw(40));
      rd(5, v);  chk("R7 div0 cause", v, tw(-13));
      rd(9, v);  chk("R7 div0 value", v, '0);
      rd(8, v);  chk("R2 saved status", v, st0);
      rd(7, v);  chk("R2 entered status", v, entry(st0, 2'b01));
      ret();
      chk("R5 ret redirect", redirect_pc, tw(40));
      chk("R5 ret valid", {53'd0, redirect_valid}, 54'd1);
      rd(7, v);  chk("R5 status restored", v, st0);
      @(negedge clk);
      chk("R5 pulse one cycle", {53'd0, redirect_valid}, '0);

      // R3 nested entry, R7 fault, R5 return from second bank, R13
      trap(2'd1, tw(-321), '0, tw(41));
      rd(5, v);  chk("R7 fault cause", v, tw(-11));
      rd(9, v);  chk("R7 fault value", v, tw(-321));
      trap(2'd0, tw(9), '0, tw(600));
      chk("R3 redirect", redirect_pc, tw(500));
      rd(7, v);  chk("R3 depth N", v, entry(entry(st0, 2'b01), 2'b11));
      rd(10, v); chk("R3 bank2 pc", v, tw(600));
      rd(11, v); chk("R3 bank2 cause", v, tw(-13));
      rd(12, v); chk("R3 bank2 status", v, entry(st0, 2'b01));
      rd(13, v); chk("R3 bank2 value", v, '0);
      rd(4, v);  chk("R3 main pc kept", v, tw(41));
      rd(5, v);  chk("R3 main cause kept", v, tw(-11));
      ret();
      chk("R5 ret bank2 redirect", redirect_pc, tw(600));
      rd(7, v);  chk("R5 ret bank2 status", v, entry(st0, 2'b01));
      @(negedge clk);
      csr_we = 1'b1; csr_addr = 4'd4; csr_wdata = tw(45);
      @(negedge clk);
      csr_we = 1'b0; ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      chk("R13 fresh saved pc", redirect_pc, tw(45));
      rd(7, v);  chk("R5 back to depth Z", v, st0);

      // R6 return at depth Z
      ret();
      chk("R6 no redirect", {53'd0, redirect_valid}, '0);
      rd(7, v);  chk("R6 status unchanged", v, st0);

      // R4 triple fault
      trap(2'd0, '0, '0, tw(1));
      trap(2'd0, '0, '0, tw(2));
      trap(2'd0, '0, '0, tw(3));
      chk("R4 mcheck", {52'd0, mcheck, gpr_clear}, 54'd3);
      chk("R4 redirect zero", {redirect_pc[WB-2:0], redirect_valid}, 54'd1);
      for (int a = 2; a <= 13; a++) begin
         rd(a, v);
         chk("R4 csr cleared", v, '0);
      end
      @(negedge clk);
      chk("R4 pulse ends", {52'd0, mcheck, gpr_clear}, '0);

      // R11 trap and return together, write dropped
      wr(2, tw(5));
      trap(2'd0, '0, '0, tw(8));
      @(negedge clk);
      exc_req = 1'b1; exc_src = 2'd0; exc_pc = tw(88); ret_req = 1'b1;
      csr_we = 1'b1; csr_addr = 4'd2; csr_wdata = tw(9);
      @(negedge clk);
      exc_req = 1'b0; ret_req = 1'b0; csr_we = 1'b0;
      rd(7, v);  chk("R11 trap wins depth", {52'd0, v[1:0]}, 54'd3);
      rd(10, v); chk("R11 bank2 pc", v, tw(88));
      rd(2, v);  chk("R11 write dropped", v, tw(5));
      ret();
      ret();
      rd(7, v);  chk("R11 unwound", v, '0);

      // R10 invalid depth code treated as Z
      wr(7, 54'b10);
      trap(2'd0, '0, '0, tw(3));
      rd(4, v);  chk("R10 main bank used", v, tw(3));
      rd(8, v);  chk("R10 raw status saved", v, 54'b10);
      rd(7, v);  chk("R10 entered", v, 54'b111101);
      ret();
      wr(7, '0);

      // R8 opcode sweep
      for (int op = -40; op <= 40; op++) begin
         logic rsv;
         logic [WB-1:0] ins;
         rsv = (op == -20) || (op == -19) || (op >= 14);
         ins = mk_insn(op, 2'b00);
         trap(2'd2, tw(3), ins, tw(op + 100));
         rd(5, v); chk("R8 opcode cause", v, (!rsv && op == SYS) ? tw(0) : tw(-10));
         rd(9, v); chk("R8 opcode value", v, (!rsv && op == SYS) ? '0 : ins);
         ret();
      end

      // R9 R10 call flavors
      for (int k = 0; k < 4; k++) begin
         logic [1:0] f;
         int exp;
         f = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : (k == 2) ? 2'b11 : 2'b10;
         exp = (k == 1) ? 1 : (k == 2) ? 2 : 0;
         trap(2'd3, '0, mk_insn(SYS, f), tw(7));
         rd(5, v); chk("R9 flavor cause", v, tw(exp));
         rd(9, v); chk("R9 flavor value", v, '0);
         ret();
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule